// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for a parallel RGB panel. It keeps a pixel counter and a line counter, both clocked by the pixel clock. From them it forms horizontal sync, vertical sync and data enable, together with a composite sync and a composite blank. It also gives the pixel position inside the visible window, a pixel request one clock ahead of each visible pixel, a start-of-frame strobe and a frame counter.

Software programs four 32-bit words:

- a total word, with the line count in the upper half and the pixel count per line in the lower half;
- an active word, laid out the same way;
- a horizontal porch word;
- a vertical porch word.

Each porch word carries the panel front porch in its upper half and the panel back porch in its lower half.

The sync pulse is always exactly one unit wide, so a correctly programmed total equals active + front porch + back porch + 1. Along each axis the order is: sync at count 0, then the back porch, then the visible region, then the front porch up to the total.

Outside the visible region the colour output carries a programmable blank colour. Every timing output has its own inversion bit. A panel-enable bit stops the raster completely.

Top module: `lcd_timing_gen`

## Requirements
- R1: While reset is asserted, and after it is released, both counters and the frame counter read zero. Reset is asynchronous and active low.
- R2: A line lasts exactly total-pixels clocks, where total-pixels is bits 15:0 of the total word. Before inversion, horizontal sync is high only in the first clock of each line.
- R3: A frame lasts exactly total-lines lines, where total-lines is bits 31:16 of the total word. The line counter advances only when the pixel counter wraps. Before inversion, vertical sync is high for the whole of line 0.
- R4: Define pixel start = back porch + 1, using bits 15:0 of the horizontal porch word, and line start the same way from the vertical porch word. Before inversion, data enable is high when both of these hold:
  - the pixel count lies in [pixel start, pixel start + active pixels), with active pixels from bits 15:0 of the active word;
  - the line count lies in the matching window, with active lines from bits 31:16 of the active word.

  The x and y outputs give the offset from the window start and read zero outside it.
- R5: The colour output equals the pixel input while data is enabled, and equals the blank colour otherwise.
- R6: Each of the following control bits inverts one output: bit 2 horizontal sync, bit 3 vertical sync, bit 4 data enable, bit 5 composite sync, bit 6 composite blank. Bit 0 enables the panel.
- R7: Before inversion, composite sync is the OR of the two syncs. Composite blank is the complement of data enable while the panel is enabled.
- R8: While bit 0 is clear:
  - both counters are held at zero;
  - every timing signal sits at its inactive level (0 before inversion);
  - x, y, pixel request and start-of-frame read zero;
  - the colour output equals the blank colour;
  - the frame counter keeps its value.
- R9: The pixel request is high exactly in the clock before each visible pixel.
- R10: Start-of-frame is a single-clock pulse at the first visible pixel of the first visible line.
- R11: The frame counter increments by one, modulo its width, on the clock edge that leaves the last pixel of the last line.
- R12: The front porch halves (bits 31:16 of both porch words) have no effect on the outputs. The total word alone sets the line and frame lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ctrl | input | 8 | Panel enable (bit 0) and output inversion bits (2..6) |
| cfg_total | input | 32 | Lines total [31:16], pixels total [15:0] |
| cfg_active | input | 32 | Active lines [31:16], active pixels [15:0] |
| cfg_hporch | input | 32 | Horizontal front porch [31:16], back porch [15:0] |
| cfg_vporch | input | 32 | Vertical front porch [31:16], back porch [15:0] |
| cfg_blank | input | COLOR_W | Colour driven outside the visible window |
| pix_rgb_i | input | COLOR_W | Pixel data from the fetch path |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| csync_o | output | 1 | Composite sync |
| cblank_o | output | 1 | Composite blank |
| rgb_o | output | COLOR_W | Colour to the panel |
| x_pos_o | output | CW | Pixel offset inside the visible window |
| y_pos_o | output | CW | Line offset inside the visible window |
| pix_req_o | output | 1 | Request for the next visible pixel |
| sof_o | output | 1 | Start-of-frame strobe |
| frame_cnt_o | output | FRAME_W | Frame counter |

## Verification
The hardest condition to reach is frame counter wrap-around. At a realistic width and panel size it needs tens of thousands of frames. The bench therefore narrows the counter width to four bits and programs a minimal 4x3 raster, so that twenty frames pass in a few hundred clocks and the modulo step is observed. A second hard case is a configuration change while the raster is running. To cover it in a controlled way, each new setting is preceded by a disabled interval, which also exercises the hold-at-zero behaviour under every inversion mask.

// File: rtl/lcdtg_pkg.sv
package lcdtg_pkg;
   localparam int unsigned CB_EN     = 0;
   localparam int unsigned CB_HS_INV = 2;
   localparam int unsigned CB_VS_INV = 3;
   localparam int unsigned CB_DE_INV = 4;
   localparam int unsigned CB_CS_INV = 5;
   localparam int unsigned CB_CB_INV = 6;

   // raw (pre-inversion) timing levels, active high
   typedef struct packed {
      logic hs;
      logic vs;
      logic de;
      logic cs;
      logic cb;
   } tg_lvl_t;
endpackage

// File: rtl/lcdtg_axis.sv
// One raster axis: counter with programmable span and visible window.
module lcdtg_axis #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          step,
   input  logic [CW-1:0] span,
   input  logic [CW-1:0] len,
   input  logic [CW-1:0] lead,
   output logic          wrap_o,
   output logic          sync_o,
   output logic          in_win_o,
   output logic          next_in_win_o,
   output logic [CW-1:0] pos_o
);
   localparam int WW = CW + 1;

   logic [CW-1:0] cnt_q;
   logic [WW-1:0] cnt_nx, win_lo, win_hi;

   assign cnt_nx = {1'b0, cnt_q} + 1'b1;
   assign win_lo = {1'b0, lead} + 1'b1;
   assign win_hi = win_lo + {1'b0, len};

   // wrap at span-1; >= keeps a shrunk span from running away
   assign wrap_o = step && (cnt_nx >= {1'b0, span});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run)   cnt_q <= '0;
      else if (step)   cnt_q <= wrap_o ? '0 : cnt_nx[CW-1:0];
   end

   assign sync_o        = (cnt_q == '0);
   assign in_win_o      = ({1'b0, cnt_q} >= win_lo) && ({1'b0, cnt_q} < win_hi);
   assign next_in_win_o = (cnt_nx >= win_lo) && (cnt_nx < win_hi);
   assign pos_o         = in_win_o ? (cnt_q - lead - 1'b1) : '0;
endmodule

// File: rtl/lcdtg_drive.sv
// Output stage: per-signal polarity and blank colour substitution.
module lcdtg_drive
   import lcdtg_pkg::*;
#(
   parameter int COLOR_W = 24
) (
   input  tg_lvl_t            lvl_i,
   input  logic [4:0]         inv_i,
   input  logic [COLOR_W-1:0] pix_i,
   input  logic [COLOR_W-1:0] blank_i,
   output logic               hsync_o,
   output logic               vsync_o,
   output logic               de_o,
   output logic               csync_o,
   output logic               cblank_o,
   output logic [COLOR_W-1:0] rgb_o
);
   localparam int NSIG = $bits(tg_lvl_t);

   logic [NSIG-1:0] lvl_v, pol_v;
   assign lvl_v = lvl_i;

   for (genvar i = 0; i < NSIG; i++) begin : g_pol
      assign pol_v[i] = lvl_v[i] ^ inv_i[i];
   end

   assign {hsync_o, vsync_o, de_o, csync_o, cblank_o} = pol_v;
   assign rgb_o = lvl_i.de ? pix_i : blank_i;
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
   import lcdtg_pkg::*;
#(
   parameter int CW      = 16,
   parameter int FRAME_W = 16,
   parameter int COLOR_W = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [7:0]         cfg_ctrl,
   input  logic [31:0]        cfg_total,
   input  logic [31:0]        cfg_active,
   input  logic [31:0]        cfg_hporch,
   input  logic [31:0]        cfg_vporch,
   input  logic [COLOR_W-1:0] cfg_blank,
   input  logic [COLOR_W-1:0] pix_rgb_i,
   output logic               hsync_o,
   output logic               vsync_o,
   output logic               de_o,
   output logic               csync_o,
   output logic               cblank_o,
   output logic [COLOR_W-1:0] rgb_o,
   output logic [CW-1:0]      x_pos_o,
   output logic [CW-1:0]      y_pos_o,
   output logic               pix_req_o,
   output logic               sof_o,
   output logic [FRAME_W-1:0] frame_cnt_o
);
   if (CW < 2 || CW > 16) begin : g_bad_cw
      $error("lcd_timing_gen: CW must lie in 2..16");
   end
   if (FRAME_W < 1) begin : g_bad_fw
      $error("lcd_timing_gen: FRAME_W must be at least 1");
   end
   if (COLOR_W < 1) begin : g_bad_cwid
      $error("lcd_timing_gen: COLOR_W must be at least 1");
   end

   logic en;
   assign en = cfg_ctrl[CB_EN];

   // front porch halves are implied by the totals
   logic unused_cfg;
   assign unused_cfg = ^{cfg_hporch[31:16], cfg_vporch[31:16], cfg_ctrl[7], cfg_ctrl[1]};

   logic          h_wrap, h_sync, h_in, h_next;
   logic          v_wrap, v_sync, v_in, v_next;
   logic [CW-1:0] h_pos, v_pos;

   lcdtg_axis #(.CW(CW)) u_hax (
      .clk(clk), .rst_n(rst_n), .run(en), .step(en),
      .span(cfg_total[CW-1:0]), .len(cfg_active[CW-1:0]), .lead(cfg_hporch[CW-1:0]),
      .wrap_o(h_wrap), .sync_o(h_sync), .in_win_o(h_in), .next_in_win_o(h_next),
      .pos_o(h_pos)
   );

   lcdtg_axis #(.CW(CW)) u_vax (
      .clk(clk), .rst_n(rst_n), .run(en), .step(h_wrap),
      .span(cfg_total[16+CW-1:16]), .len(cfg_active[16+CW-1:16]), .lead(cfg_vporch[CW-1:0]),
      .wrap_o(v_wrap), .sync_o(v_sync), .in_win_o(v_in), .next_in_win_o(v_next),
      .pos_o(v_pos)
   );

   logic unused_vnext;
   assign unused_vnext = v_next;

   tg_lvl_t lvl;
   always_comb begin
      lvl.hs = en && h_sync;
      lvl.vs = en && v_sync;
      lvl.de = en && h_in && v_in;
      lvl.cs = lvl.hs || lvl.vs;
      lvl.cb = en && !lvl.de;
   end

   lcdtg_drive #(.COLOR_W(COLOR_W)) u_drv (
      .lvl_i(lvl),
      .inv_i({cfg_ctrl[CB_HS_INV], cfg_ctrl[CB_VS_INV], cfg_ctrl[CB_DE_INV],
              cfg_ctrl[CB_CS_INV], cfg_ctrl[CB_CB_INV]}),
      .pix_i(pix_rgb_i), .blank_i(cfg_blank),
      .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
      .csync_o(csync_o), .cblank_o(cblank_o), .rgb_o(rgb_o)
   );

   assign x_pos_o   = (en && h_in) ? h_pos : '0;
   assign y_pos_o   = (en && v_in) ? v_pos : '0;
   assign pix_req_o = en && v_in && h_next;
   assign sof_o     = lvl.de && (h_pos == '0) && (v_pos == '0);

   logic [FRAME_W-1:0] frame_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       frame_q <= '0;
      else if (v_wrap)  frame_q <= frame_q + 1'b1;
   end
   assign frame_cnt_o = frame_q;
endmodule

// File: rtl/lcd_timing_gen_chk.sv
module lcd_timing_gen_chk #(
   parameter int CW      = 16,
   parameter int FRAME_W = 16,
   parameter int COLOR_W = 24
) (
   input logic               clk,
   input logic               rst_n,
   input logic [7:0]         cfg_ctrl,
   input logic [31:0]        cfg_total,
   input logic [31:0]        cfg_active,
   input logic [31:0]        cfg_hporch,
   input logic [31:0]        cfg_vporch,
   input logic [COLOR_W-1:0] cfg_blank,
   input logic [COLOR_W-1:0] pix_rgb_i,
   input logic               de_o,
   input logic               cblank_o,
   input logic [COLOR_W-1:0] rgb_o,
   input logic [CW-1:0]      x_pos_o,
   input logic [CW-1:0]      y_pos_o,
   input logic               pix_req_o,
   input logic               sof_o,
   input logic [FRAME_W-1:0] frame_cnt_o
);
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_ctrl[0] |-> (x_pos_o == '0 && y_pos_o == '0 && !pix_req_o && !sof_o && rgb_o == cfg_blank));

   assert_sof_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sof_o |=> !sof_o);

   assert_frame_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_cnt_o != $past(frame_cnt_o)) |-> (frame_cnt_o == FRAME_W'($past(frame_cnt_o) + 1'b1)));

   assert_blank_vs_de_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ctrl[0] |-> ((cblank_o ^ cfg_ctrl[6]) == !(de_o ^ cfg_ctrl[4])));

   assert_req_lead_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pix_req_o ##1 ($stable(cfg_ctrl) && $stable(cfg_total) && $stable(cfg_active)
                     && $stable(cfg_hporch) && $stable(cfg_vporch))
      |-> (de_o != cfg_ctrl[4]));

   assert_pixel_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_ctrl[0] && (de_o != cfg_ctrl[4])) |-> (rgb_o == pix_rgb_i));
endmodule

bind lcd_timing_gen lcd_timing_gen_chk #(.CW(CW), .FRAME_W(FRAME_W), .COLOR_W(COLOR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl), .cfg_total(cfg_total),
   .cfg_active(cfg_active), .cfg_hporch(cfg_hporch), .cfg_vporch(cfg_vporch),
   .cfg_blank(cfg_blank), .pix_rgb_i(pix_rgb_i), .de_o(de_o), .cblank_o(cblank_o),
   .rgb_o(rgb_o), .x_pos_o(x_pos_o), .y_pos_o(y_pos_o), .pix_req_o(pix_req_o),
   .sof_o(sof_o), .frame_cnt_o(frame_cnt_o)
);

// File: tb/test_lcd_timing_gen.sv
`timescale 1ns/1ps
module test_lcd_timing_gen;
   localparam int CW = 16;
   localparam int FW = 4;
   localparam int COLW = 24;

   typedef struct packed {
      logic [15:0] htot, vtot, hact, vact, hbp, hfp, vbp, vfp;
      logic [7:0]  ctrl;
      logic [23:0] blank, pix;
      logic [15:0] cyc;
   } vec_t;

   // vector 2 carries junk front porch fields (R12)
   // vector 3 runs past the 4-bit frame counter wrap (R11)
   localparam vec_t VECS [5] = '{
      '{16'd10, 16'd6, 16'd5, 16'd3, 16'd2, 16'd2,      16'd1, 16'd1,      8'h01, 24'hFF00FF, 24'h123456, 16'd130},
      '{16'd8,  16'd5, 16'd4, 16'd2, 16'd1, 16'd2,      16'd1, 16'd1,      8'h7D, 24'h0A0B0C, 24'h654321, 16'd90},
      '{16'd9,  16'd4, 16'd3, 16'd1, 16'd3, 16'hBEEF,   16'd1, 16'h7777,   8'h15, 24'h111111, 24'hABCDEF, 16'd80},
      '{16'd4,  16'd3, 16'd1, 16'd1, 16'd1, 16'd1,      16'd0, 16'd1,      8'h29, 24'h000000, 24'hFFFFFF, 16'd260},
      '{16'd6,  16'd4, 16'd2, 16'd2, 16'd0, 16'd3,      16'd0, 16'd1,      8'h41, 24'h000001, 24'h000002, 16'd60}
   };

   logic clk = 1'b0;
   logic rst_n;
   logic [7:0] cfg_ctrl;
   logic [31:0] cfg_total, cfg_active, cfg_hporch, cfg_vporch;
   logic [COLW-1:0] cfg_blank, pix_rgb;
   logic hsync, vsync, de, csync, cblank, pix_req, sof;
   logic [COLW-1:0] rgb;
   logic [CW-1:0] xpos, ypos;
   logic [FW-1:0] fcnt;

   always #2.5 clk = ~clk;

   lcd_timing_gen #(.CW(CW), .FRAME_W(FW), .COLOR_W(COLW)) i_lcd_timing_gen (
      .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl), .cfg_total(cfg_total),
      .cfg_active(cfg_active), .cfg_hporch(cfg_hporch), .cfg_vporch(cfg_vporch),
      .cfg_blank(cfg_blank), .pix_rgb_i(pix_rgb),
      .hsync_o(hsync), .vsync_o(vsync), .de_o(de), .csync_o(csync), .cblank_o(cblank),
      .rgb_o(rgb), .x_pos_o(xpos), .y_pos_o(ypos), .pix_req_o(pix_req), .sof_o(sof),
      .frame_cnt_o(fcnt)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   int hc = 0, vc = 0;
   logic [FW-1:0] fc = '0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h (h=%0d v=%0d)", tag, act, exp, hc, vc);
      end
   endtask

   task automatic load(input vec_t v);
      cfg_total  = {v.vtot, v.htot};
      cfg_active = {v.vact, v.hact};
      cfg_hporch = {v.hfp, v.hbp};
      cfg_vporch = {v.vfp, v.vbp};
      cfg_blank  = v.blank;
      pix_rgb    = v.pix;
   endtask

   // model of the raster state after each clock edge
   task automatic advance();
      int ht, vt;
      ht = int'(cfg_total[15:0]);
      vt = int'(cfg_total[31:16]);
      if (!rst_n || !cfg_ctrl[0]) begin
         hc = 0; vc = 0;
         if (!rst_n) fc = '0;
      end else if (hc + 1 >= ht) begin
         hc = 0;
         if (vc + 1 >= vt) begin vc = 0; fc = fc + 1'b1; end
         else vc = vc + 1;
      end else hc = hc + 1;
   endtask

   task automatic compare_all();
      bit en, hin, vin, hn, hs, vs, dd, cs, cb;
      int hst, vst, ha, va;
      en  = cfg_ctrl[0];
      hst = int'(cfg_hporch[15:0]) + 1;
      vst = int'(cfg_vporch[15:0]) + 1;
      ha  = int'(cfg_active[15:0]);
      va  = int'(cfg_active[31:16]);
      hin = (hc >= hst) && (hc < hst + ha);
      vin = (vc >= vst) && (vc < vst + va);
      hn  = (hc + 1 >= hst) && (hc + 1 < hst + ha);
      hs  = en && hc == 0;
      vs  = en && vc == 0;
      dd  = en && hin && vin;
      cs  = hs || vs;
      cb  = en && !dd;
      chk("R2/R6 hsync",  32'(hsync),  32'(hs ^ cfg_ctrl[2]));
      chk("R3/R6 vsync",  32'(vsync),  32'(vs ^ cfg_ctrl[3]));
      chk("R4/R6 de",     32'(de),     32'(dd ^ cfg_ctrl[4]));
      chk("R7 csync",     32'(csync),  32'(cs ^ cfg_ctrl[5]));
      chk("R7 cblank",    32'(cblank), 32'(cb ^ cfg_ctrl[6]));
      chk("R5 rgb",       32'(rgb),    32'(dd ? pix_rgb : cfg_blank));
      chk("R4 x_pos",     32'(xpos),   (en && hin) ? 32'(hc - hst) : 32'd0);
      chk("R4 y_pos",     32'(ypos),   (en && vin) ? 32'(vc - vst) : 32'd0);
      chk("R9 pix_req",   32'(pix_req), 32'(en && vin && hn));
      chk("R10 sof",      32'(sof),    32'(dd && hc == hst && vc == vst));
      chk("R11 frame",    32'(fcnt),   32'(fc));
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         advance();
         @(negedge clk);
         compare_all();
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      cfg_ctrl = 8'h00;
      load(VECS[0]);
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 x_pos", 32'(xpos), 32'd0);
      chk("R1 y_pos", 32'(ypos), 32'd0);
      chk("R1 frame", 32'(fcnt), 32'd0);
      chk("R1 de",    32'(de),   32'd0);
      rst_n = 1'b1;
      run(2);

      for (int v = 0; v < 5; v++) begin
         logic [FW-1:0] held;
         load(VECS[v]);
         held = fcnt;
         cfg_ctrl = VECS[v].ctrl & 8'hFE;
         run(4);
         // R8: disabled interval keeps counters at zero and outputs idle
         chk("R8 idle x",     32'(xpos),    32'd0);
         chk("R8 idle req",   32'(pix_req), 32'd0);
         chk("R8 idle rgb",   32'(rgb),     32'(cfg_blank));
         chk("R8 idle hsync", 32'(hsync),   32'(cfg_ctrl[2]));
         chk("R8 frame held", 32'(fcnt),    32'(held));
         cfg_ctrl = VECS[v].ctrl;
         run(int'(VECS[v].cyc));
      end

      // R1: asynchronous reset in mid-frame
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      hc = 0; vc = 0; fc = '0;
      chk("R1 async frame", 32'(fcnt), 32'd0);
      chk("R1 async x",     32'(xpos), 32'd0);
      chk("R1 async vsync", 32'(vsync), 32'(1'b1 ^ cfg_ctrl[3]));

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule